// File: doc/BRIEF.md
# Packed Half-Precision Exponent Extraction Unit

This unit takes a vector of half-precision (FP16) words and returns, in every lane, floor(log2(|x|)) as an FP16 number. A lane finds the exponent of its input and turns it into a signed integer. Subnormal inputs are normalized before their exponent is taken. The integer is then encoded exactly as an FP16 value. NaN, infinity and zero inputs are handled as special cases.

The lanes sit under a per-lane write mask, and the mask can be switched off as a whole. A masked-off lane either keeps the old destination word (merge) or is cleared (zeroing). A broadcast control makes every lane compute from element 0 of the source. The unit has two sticky status flags. One records that a signaling NaN was processed and the other that a subnormal was processed. Only written lanes can set them, and only reset clears them.

The lane datapath is combinational. The result vector and the flags are captured on an input strobe, and a valid pulse marks them one cycle later.

Top module: `fp16x_getexp_vec`

## Requirements
- R1: A lane with a normal input (biased exponent field e at bits 14:10, with 1 <= e <= 30) yields e-15 encoded exactly as FP16. An integer of 0 encodes as 0x0000, so 1.0 (0x3C00) gives 0x0000, 2.0 (0x4000) gives 0x3C00, and 0x7BFF gives 15 (0x4B80).
- R2: The sign bit (bit 15) of an input has no effect on the result of its lane. For example, 0xBC00 gives 0x0000 and 0x8001 gives the same result as 0x0001.
- R3: A subnormal input (exponent field 0, fraction bits 9:0 nonzero) yields k-24 as FP16, where k is the index of the highest set fraction bit. Fraction bit 9 set gives -15 (0xCB80), and 0x0001 gives -24 (0xCE00).
- R4: A NaN input (exponent field 31, fraction nonzero) yields 0x7C00 | 0x0200 | fraction bits 8:0. The sign bit of the result is 0 and fraction bit 9 is forced to 1. A signaling NaN is one whose fraction bit 9 is 0.
- R5: An infinity of either sign yields +INF (0x7C00), and a zero of either sign yields -INF (0xFC00).
- R6: A lane is written when mask_en is 0 or its lane_mask bit is 1. With mask_en at 1, a lane whose mask bit is 0 takes 0x0000 if zero_mode is 1. If zero_mode is 0, it takes the matching word of old_dst.
- R7: When bcast is 1, every written lane computes from source word 0 (bits 15:0) instead of its own word.
- R8: flag_inv goes to 1 when a written lane processed a signaling NaN. flag_den goes to 1 when a written lane processed a subnormal. Masked-off lanes never set either flag, and both flags stay set until reset.
- R9: The results of a strobe taken at a rising clock edge with in_valid high appear on res_vec at that edge, and res_valid is high for exactly that following cycle. Without a strobe, res_valid is 0 and res_vec holds its value.
- R10: While rst_n is low, res_vec, res_valid, flag_inv and flag_den are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: capture a new result this edge |
| src_vec | input | VEC_W | Packed FP16 source words, lane i at bits 16i+15:16i |
| old_dst | input | VEC_W | Previous destination words used for merge masking |
| lane_mask | input | VEC_W/16 | Per-lane write mask, bit i for lane i |
| mask_en | input | 1 | 1 applies lane_mask, 0 writes every lane |
| zero_mode | input | 1 | 1 clears masked-off lanes, 0 merges old_dst |
| bcast | input | 1 | 1 feeds source word 0 to every lane |
| res_vec | output | VEC_W | Registered result vector |
| res_valid | output | 1 | High the cycle after a strobe |
| flag_inv | output | 1 | Sticky signaling-NaN flag |
| flag_den | output | 1 | Sticky subnormal-input flag |

## Verification
The result vector, res_valid and both flags all come from the same register, so they are all due exactly one rising edge after the strobe. The bench drives each operation at a falling edge and samples all four outputs at the next falling edge, which lies after that single register stage. After some operations it waits one more falling edge to confirm that res_valid has dropped and that res_vec has held. The masked-flag case is run straight after a reset, so that the sticky flags start from 0 and a stray contribution from a masked-off lane would show.

// File: rtl/fp16x_pkg.sv
package fp16x_pkg;
    localparam int          HALF_W    = 16;
    localparam int          FRAC_W    = 10;
    localparam logic [4:0]  EXP_BIAS  = 5'd15;
    localparam logic [15:0] HALF_PINF = 16'h7C00;
    localparam logic [15:0] HALF_NINF = 16'hFC00;

    typedef enum logic [2:0] {
        KIND_NORM,
        KIND_SUB,
        KIND_ZERO,
        KIND_INF,
        KIND_NAN
    } lane_kind_e;
endpackage

// File: rtl/fp16x_int2half.sv
module fp16x_int2half
    import fp16x_pkg::*;
(
    input  logic signed [5:0] int_val,
    output logic [15:0]       half_val
);
    logic       neg;
    logic [5:0] mag;
    logic [2:0] msb;
    logic [4:0] exp_f;
    logic [9:0] frac_f;

    always_comb begin
        neg = int_val[5];
        mag = neg ? 6'(-int_val) : 6'(int_val);
        msb = 3'd0;
        for (int b = 0; b < 6; b++) begin
            if (mag[b]) msb = 3'(b);
        end
        exp_f  = EXP_BIAS + {2'b00, msb};
        frac_f = 10'({mag, 10'b0} >> msb);
        if (mag == 6'd0) half_val = 16'h0000;
        else             half_val = {neg, exp_f, frac_f};
    end
endmodule

// File: rtl/fp16x_lane.sv
module fp16x_lane
    import fp16x_pkg::*;
(
    input  logic [14:0] mag_in,
    output logic [15:0] lane_out,
    output logic        is_snan,
    output logic        is_sub
);
    logic [4:0]        e_fld;
    logic [9:0]        f_fld;
    lane_kind_e        kind;
    logic [3:0]        lead_z;
    logic signed [5:0] unb_exp;
    logic [15:0]       conv_out;

    assign e_fld = mag_in[14:10];
    assign f_fld = mag_in[9:0];

    always_comb begin
        if (e_fld == 5'h1F)     kind = (f_fld != '0) ? KIND_NAN : KIND_INF;
        else if (e_fld == 5'h0) kind = (f_fld != '0) ? KIND_SUB : KIND_ZERO;
        else                    kind = KIND_NORM;
    end

    always_comb begin
        lead_z = 4'd9;
        for (int b = 0; b < FRAC_W; b++) begin
            if (f_fld[b]) lead_z = 4'(FRAC_W - 1 - b);
        end
    end

    always_comb begin
        if (kind == KIND_SUB) unb_exp = -6'sd15 - $signed({2'b00, lead_z});
        else                  unb_exp = $signed({1'b0, e_fld}) - 6'sd15;
    end

    fp16x_int2half u_conv (
        .int_val  (unb_exp),
        .half_val (conv_out)
    );

    always_comb begin
        is_snan = 1'b0;
        is_sub  = 1'b0;
        unique case (kind)
            KIND_NAN: begin
                lane_out = {1'b0, 5'h1F, 1'b1, f_fld[8:0]};
                is_snan  = ~f_fld[9];
            end
            KIND_INF:  lane_out = HALF_PINF;
            KIND_ZERO: lane_out = HALF_NINF;
            KIND_SUB: begin
                lane_out = conv_out;
                is_sub   = 1'b1;
            end
            default:   lane_out = conv_out;
        endcase
    end
endmodule

// File: rtl/fp16x_getexp_vec.sv
module fp16x_getexp_vec
    import fp16x_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [VEC_W-1:0]          src_vec,
    input  logic [VEC_W-1:0]          old_dst,
    input  logic [VEC_W/HALF_W-1:0]   lane_mask,
    input  logic                      mask_en,
    input  logic                      zero_mode,
    input  logic                      bcast,
    output logic [VEC_W-1:0]          res_vec,
    output logic                      res_valid,
    output logic                      flag_inv,
    output logic                      flag_den
);
    localparam int LANES = VEC_W / HALF_W;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic             vld;
        logic             inv;
        logic             den;
    } out_s;

    out_s              st_d, st_q;
    logic [15:0]       lane_y [LANES];
    logic [LANES-1:0]  lane_snan;
    logic [LANES-1:0]  lane_sub;
    logic [LANES-1:0]  wr_en;

    assign wr_en = mask_en ? lane_mask : '1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [14:0] lane_mag;
        assign lane_mag = bcast ? src_vec[14:0] : src_vec[g*HALF_W +: 15];
        fp16x_lane u_lane (
            .mag_in   (lane_mag),
            .lane_out (lane_y[g]),
            .is_snan  (lane_snan[g]),
            .is_sub   (lane_sub[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_en[i])       st_d.res[i*HALF_W +: HALF_W] = lane_y[i];
                else if (zero_mode) st_d.res[i*HALF_W +: HALF_W] = '0;
                else                st_d.res[i*HALF_W +: HALF_W] = old_dst[i*HALF_W +: HALF_W];
            end
            st_d.inv = st_q.inv | (|(wr_en & lane_snan));
            st_d.den = st_q.den | (|(wr_en & lane_sub));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vec   = st_q.res;
    assign res_valid = st_q.vld;
    assign flag_inv  = st_q.inv;
    assign flag_den  = st_q.den;
endmodule

// File: rtl/fp16x_getexp_chk.sv
module fp16x_getexp_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mask_en,
    input logic             zero_mode,
    input logic             lane0_mask,
    input logic [14:0]      lane0_mag,
    input logic [15:0]      lane0_old,
    input logic [VEC_W-1:0] res_vec,
    input logic             res_valid,
    input logic             flag_inv,
    input logic             flag_den
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R9
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_vec)); // R9
    AST_INV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inv |=> flag_inv); // R8
    AST_DEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_den |=> flag_den); // R8
    AST_ZERO_MASKED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && !lane0_mask) |=> (res_vec[15:0] == 16'h0000)); // R6
    AST_MERGE_MASKED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !zero_mode && !lane0_mask) |=> (res_vec[15:0] == $past(lane0_old))); // R6
    AST_ZERO_TO_NINF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!mask_en || lane0_mask) && lane0_mag == 15'h0) |=> (res_vec[15:0] == 16'hFC00)); // R5
endmodule

bind fp16x_getexp_vec fp16x_getexp_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mask_en    (mask_en),
    .zero_mode  (zero_mode),
    .lane0_mask (lane_mask[0]),
    .lane0_mag  (src_vec[14:0]),
    .lane0_old  (old_dst[15:0]),
    .res_vec    (res_vec),
    .res_valid  (res_valid),
    .flag_inv   (flag_inv),
    .flag_den   (flag_den)
);

// File: tb/sim_fp16x_getexp_vec.sv
`timescale 1ns/1ps
module sim_fp16x_getexp_vec;
    localparam int VW = 128;
    localparam int NL = VW / 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] old_dst = '0;
    logic [NL-1:0] lane_mask = '0;
    logic          mask_en = 1'b0;
    logic          zero_mode = 1'b0;
    logic          bcast = 1'b0;
    logic [VW-1:0] res_vec;
    logic          res_valid;
    logic          flag_inv;
    logic          flag_den;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [VW-1:0] m_res;
    logic          m_inv, m_den;

    always #5 clk = ~clk;

    fp16x_getexp_vec #(.VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_mode(zero_mode), .bcast(bcast), .res_vec(res_vec),
        .res_valid(res_valid), .flag_inv(flag_inv), .flag_den(flag_den)
    );

    task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] int_to_half(input int n);
        int m, ex, fr;
        if (n == 0) return 16'h0000;
        m  = (n < 0) ? -n : n;
        ex = 0;
        while ((1 << (ex + 1)) <= m) ex++;
        fr = ((m << 10) >> ex) - 1024;
        return {n < 0, 5'(ex + 15), 10'(fr)};
    endfunction

    function automatic logic [15:0] ref_lane(input logic [15:0] x);
        int k;
        logic [4:0] e;
        logic [9:0] f;
        e = x[14:10];
        f = x[9:0];
        if (e == 5'h1F && f != 0) return {6'b011111, 1'b1, f[8:0]};
        if (e == 5'h1F) return 16'h7C00;
        if (e == 0 && f == 0) return 16'hFC00;
        if (e == 0) begin
            k = 0;
            for (int b = 0; b < 10; b++) if (f[b]) k = b;
            return int_to_half(k - 24);
        end
        return int_to_half(int'(e) - 15);
    endfunction

    function automatic logic [15:0] rand_half();
        logic [15:0] h;
        int c;
        c = $urandom % 8;
        h = 16'($urandom);
        case (c)
            0: h[14:0] = '0;
            1: h[14:0] = 15'h7C00;
            2: h[14:9] = 6'b111111;
            3: begin h[14:9] = 6'b111110; if (h[8:0] == 0) h[0] = 1'b1; end
            4, 5: begin h[14:10] = '0; if (h[9:0] == 0) h[3] = 1'b1; end
            default: h[14:10] = 5'(1 + ($urandom % 30));
        endcase
        return h;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(res_vec == '0 && !res_valid && !flag_inv && !flag_den, "R10 reset state",
              {res_vec[VW-4:0], res_valid, flag_inv, flag_den}, '0);
        rst_n = 1'b1;
        m_res = '0; m_inv = 1'b0; m_den = 1'b0;
    endtask

    task automatic apply(input logic [VW-1:0] s, input logic [VW-1:0] o, input logic [NL-1:0] mk,
                         input bit me, input bit zm, input bit bc, input string req);
        logic [15:0] tx;
        @(negedge clk);
        src_vec = s; old_dst = o; lane_mask = mk; mask_en = me; zero_mode = zm; bcast = bc;
        in_valid = 1'b1;
        for (int i = 0; i < NL; i++) begin
            tx = bc ? s[15:0] : s[i*16 +: 16];
            if (!me || mk[i]) begin
                m_res[i*16 +: 16] = ref_lane(tx);
                if (tx[14:10] == 5'h1F && tx[9] == 1'b0 && tx[8:0] != 0) m_inv = 1'b1;
                if (tx[14:10] == 5'h0 && tx[9:0] != 0) m_den = 1'b1;
            end else begin
                m_res[i*16 +: 16] = zm ? 16'h0000 : o[i*16 +: 16];
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(res_vec == m_res, req, res_vec, m_res);
        check(res_valid == 1'b1, "R9 valid one cycle after strobe", VW'(res_valid), VW'(1));
        check(flag_inv == m_inv, "R8 invalid flag", VW'(flag_inv), VW'(m_inv));
        check(flag_den == m_den, "R8 denormal flag", VW'(flag_den), VW'(m_den));
    endtask

    task automatic check_idle();
        @(negedge clk);
        check(!res_valid && res_vec == m_res, "R9 idle hold", res_vec, m_res);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_res = '0; m_inv = 1'b0; m_den = 1'b0;
        do_reset();
        // R8: masked-off sNaN and subnormals must not set flags; R6 merge
        apply({16'h7C01, 16'h0001, 16'h7D00, 16'h0200, 16'h7C02, 16'h0010, 16'h7C03, 16'h4000},
              {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888},
              8'h01, 1'b1, 1'b0, 1'b0, "R8 R6 masked lanes merge, no flags");
        check_idle();
        // R1 R2 normal inputs
        apply({16'h3C00, 16'h4000, 16'h7BFF, 16'h0400, 16'hBC00, 16'hC800, 16'h3800, 16'h3555},
              '0, '0, 1'b0, 1'b0, 1'b0, "R1 R2 normal exponents");
        check(res_vec[127:112] == 16'h0000 && res_vec[95:80] == 16'h4B80, "R1 explicit 1.0 and max",
              res_vec, {16'h0000, 16'h3C00, 16'h4B80, VW-48'(0)});
        // R3 subnormals
        apply({16'h0200, 16'h0001, 16'h8001, 16'h03FF, 16'h0100, 16'h0010, 16'h8300, 16'h0002},
              '0, '0, 1'b0, 1'b0, 1'b0, "R3 R2 subnormal normalization");
        check(res_vec[111:96] == 16'hCE00 && res_vec[127:112] == 16'hCB80, "R3 explicit -24 and -15",
              res_vec, m_res);
        // R4 R5 specials
        apply({16'h7C00, 16'hFC00, 16'h0000, 16'h8000, 16'h7E01, 16'h7C01, 16'hFD23, 16'hFE00},
              '0, '0, 1'b0, 1'b0, 1'b0, "R4 R5 special values");
        check(res_vec[47:0] == {16'h7E01, 16'h7F23, 16'h7E00}, "R4 NaN quieting",
              res_vec, m_res);
        check_idle();
        // R6 zeroing
        apply({8{16'h4400}}, {8{16'hABCD}}, 8'hA5, 1'b1, 1'b1, 1'b0, "R6 zeroing mask");
        // R6 mask disabled writes all lanes
        apply({8{16'h5000}}, {8{16'h1234}}, 8'h00, 1'b0, 1'b1, 1'b0, "R6 mask disabled");
        // R7 broadcast
        apply({16'h3C00, 16'h7C00, 16'h0000, 16'h7E00, 16'h0001, 16'h3800, 16'h4000, 16'h5800},
              {8{16'h0F0F}}, 8'h3C, 1'b1, 1'b0, 1'b1, "R7 broadcast element 0");
        // random mix
        for (int t = 0; t < 400; t++) begin
            logic [VW-1:0] s, o;
            for (int i = 0; i < NL; i++) begin
                s[i*16 +: 16] = rand_half();
                o[i*16 +: 16] = 16'($urandom);
            end
            if (t == 200) do_reset();
            apply(s, o, NL'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0,
                  "R1 R3 R4 R5 R6 R7 random vector");
            if (t % 50 == 0) check_idle();
        end
        do_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule